// File: doc/BRIEF.md
# Serial/Parallel Remote Loopback Controller

This block models the digital side of a 16-bit serializer/deserializer with two remote loopback paths. Every cycle of the recovered serial clock, one received bit enters a deserializer that builds 16-bit words, most significant bit first. The word boundary is fixed by a phase counter that starts at reset. Each finished word is presented on a parallel output together with a one-cycle strobe that runs at one sixteenth of the bit rate.

On the transmit side, a small synchronous FIFO takes one word per strobe and feeds a serializer. The word comes from the host, or from the receive path when parallel remote loopback is on. Any change of the parallel-loopback enable raises a one-cycle FIFO reset that flushes the FIFO.

A single active-low control input has two meanings. While PRBS test mode is off, holding it low routes the received bit straight to the serial output and flags the recovered clock as the transmit clock. While PRBS test mode is on, loopback through this input is blocked, and a falling edge on it gives a one-cycle clear pulse for the external PRBS error indicator.

Top module: `serdes_loop_ctrl`

## Requirements
- R1: Bits received in cycles 16f to 16f+15 after reset release form word f. The bit of cycle 16f is bit 15 (the bit sent first is the MSB). `rx_word` shows word f from cycle 16f+16 until the next word replaces it.
- R2: `rx_word_stb` is high for exactly one cycle, in cycles 16, 32, 48 and so on, and is low in every other cycle.
- R3: When `ctl_n` is 0 and `prbs_en` is 0, `tx_bit` equals `rx_bit` in the same cycle and `tx_clk_from_rx` is 1. Otherwise `tx_clk_from_rx` is 0.
- R4: Deserialization and `rx_word_stb` continue unchanged while serial remote loopback is active.
- R5: When `prbs_en` is 1, `ctl_n` low produces no loopback. A 1-to-0 change of `ctl_n` seen in cycle k gives `prbs_clr` = 1 in cycle k+1 only. `prbs_clr` is never 1 after a cycle in which `prbs_en` was 0.
- R6: In a strobe cycle the FIFO is written with `rx_word` when `ploop_en` is 1, and with `tx_word` when `ploop_en` is 0.
- R7: A word written in the strobe cycle 16f is sent on `tx_bit` MSB first in cycles 16f+16 to 16f+31. If no word is waiting at the end of cycle 16f+15, the following 16 cycles send zeros.
- R8: `fifo_rst` is 1 in the cycle after any cycle in which `ploop_en` differs from its value in the cycle before. Reset counts as a 0 for this comparison. A `fifo_rst` cycle empties the FIFO, so a word written earlier in that frame is never sent, and a write in that same cycle is dropped.
- R9: When serial loopback (R3) and `ploop_en` are both active, `tx_bit` follows `rx_bit`.
- R10: While `rst_n` is 0, `rx_word`, `rx_word_stb`, `tx_bit`, `fifo_rst` and `prbs_clr` are all 0, provided `ctl_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| tx_word | input | 16 | Host transmit word, sampled in strobe cycles |
| prbs_en | input | 1 | PRBS test mode enable |
| ctl_n | input | 1 | Dual-function input: serial loopback (low) or PRBS error clear (falling edge) |
| ploop_en | input | 1 | Parallel remote loopback enable |
| tx_bit | output | 1 | Serial transmit bit |
| tx_clk_from_rx | output | 1 | 1 when the recovered clock drives the transmit clock |
| rx_word | output | 16 | Deserialized receive word |
| rx_word_stb | output | 1 | One-cycle strobe for each new receive word |
| fifo_rst | output | 1 | One-cycle transmit FIFO reset request |
| prbs_clr | output | 1 | One-cycle PRBS error-clear pulse |

## Verification
The hardest case to reach is a FIFO flush that lands between the write of a word and its read into the serializer. In that case the word must vanish and a frame of zeros must follow. The stimulus toggles `ploop_en` a few cycles into a frame, so the flush falls after that frame's write and before its read. It does this once on enabling and once on disabling. Further schedules overlay serial loopback on active parallel loopback, and drive single-cycle and multi-cycle low pulses on `ctl_n` during PRBS mode. A cycle-by-cycle model in the bench predicts every output from these schedules.

// File: rtl/slb_pkg.sv
package slb_pkg;

   typedef enum logic [1:0] {
      LB_NONE   = 2'd0,
      LB_SERIAL = 2'd1,
      LB_PRBS   = 2'd2
   } lb_mode_e;

   function automatic int unsigned addr_bits(int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/slb_deser.sv
module slb_deser #(
   parameter int unsigned WORD_W    = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   output logic              phase_last,
   output logic [WORD_W-1:0] word,
   output logic              word_stb
);
   localparam int unsigned CW = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST_PH = CW'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("slb_deser: WORD_W must be at least 2");
      end
   endgenerate

   logic [CW-1:0]     phase_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] shreg_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_nxt = {shreg_q[WORD_W-2:0], rx_bit};
      end else begin : g_lsb
         assign shreg_nxt = {rx_bit, shreg_q[WORD_W-1:1]};
      end
   endgenerate

   assign phase_last = (phase_q == LAST_PH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         shreg_q  <= '0;
         word     <= '0;
         word_stb <= 1'b0;
      end else begin
         phase_q  <= phase_last ? '0 : phase_q + 1'b1;
         shreg_q  <= shreg_nxt;
         word_stb <= phase_last;
         if (phase_last) begin
            word <= shreg_nxt;
         end
      end
   end

   a_r2_stb_at_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> (phase_q == '0));

   a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   a_r1_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(phase_last) |-> $stable(word));

endmodule

// File: rtl/slb_fifo.sv
module slb_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   import slb_pkg::*;

   localparam int unsigned AW = addr_bits(DEPTH);
   localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
   localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("slb_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("slb_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic [AW:0]   count;
   logic          do_wr, do_rd;

   assign empty   = (count == '0);
   assign full    = (count == DEPTH_C);
   assign do_wr   = wr_en & ~full & ~flush;
   assign do_rd   = rd_en & ~empty & ~flush;
   assign rd_data = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_ptr == LAST_A) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == LAST_A) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_inc;
         if (do_rd) rd_ptr <= rd_inc;
         unique case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);

   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/slb_ser.sv
module slb_ser #(
   parameter int unsigned WORD_W    = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              valid,
   input  logic [WORD_W-1:0] data,
   output logic              ser_bit
);
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_shift;

   generate
      if (MSB_FIRST) begin : g_msb
         assign ser_bit  = sh_q[WORD_W-1];
         assign sh_shift = {sh_q[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign ser_bit  = sh_q[0];
         assign sh_shift = {1'b0, sh_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= valid ? data : '0;
      end else begin
         sh_q <= sh_shift;
      end
   end

   a_r7_idle_sends_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !valid) |=> !ser_bit);

endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic prbs_en,
   input  logic ctl_n,
   input  logic ploop_en,
   output logic serial_loop,
   output logic fifo_rst,
   output logic prbs_clr
);
   import slb_pkg::*;

   lb_mode_e mode;
   logic     ploop_q;
   logic     ctl_q;

   always_comb begin
      if (prbs_en)     mode = LB_PRBS;
      else if (!ctl_n) mode = LB_SERIAL;
      else             mode = LB_NONE;
   end

   assign serial_loop = (mode == LB_SERIAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ploop_q  <= 1'b0;
         ctl_q    <= 1'b1;
         fifo_rst <= 1'b0;
         prbs_clr <= 1'b0;
      end else begin
         ploop_q  <= ploop_en;
         ctl_q    <= ctl_n;
         fifo_rst <= ploop_en ^ ploop_q;
         prbs_clr <= (mode == LB_PRBS) & ctl_q & ~ctl_n;
      end
   end

   a_r8_rst_after_change: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |-> (ploop_q != $past(ploop_q)));

   a_r5_clr_needs_prbs: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_clr |-> ($past(prbs_en) && !$past(ctl_n)));

   a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_clr |=> !prbs_clr);

endmodule

// File: rtl/serdes_loop_ctrl.sv
module serdes_loop_ctrl #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter bit          MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              prbs_en,
   input  logic              ctl_n,
   input  logic              ploop_en,
   output logic              tx_bit,
   output logic              tx_clk_from_rx,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_word_stb,
   output logic              fifo_rst,
   output logic              prbs_clr
);
   logic              phase_last;
   logic              serial_loop;
   logic              ser_bit;
   logic              fifo_empty;
   logic              fifo_full;
   logic [WORD_W-1:0] fifo_wdata;
   logic [WORD_W-1:0] fifo_rdata;

   slb_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .prbs_en     (prbs_en),
      .ctl_n       (ctl_n),
      .ploop_en    (ploop_en),
      .serial_loop (serial_loop),
      .fifo_rst    (fifo_rst),
      .prbs_clr    (prbs_clr)
   );

   slb_deser #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_bit     (rx_bit),
      .phase_last (phase_last),
      .word       (rx_word),
      .word_stb   (rx_word_stb)
   );

   assign fifo_wdata = ploop_en ? rx_word : tx_word;

   slb_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (fifo_rst),
      .wr_en   (rx_word_stb),
      .wr_data (fifo_wdata),
      .rd_en   (phase_last),
      .rd_data (fifo_rdata),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   slb_ser #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (phase_last),
      .valid   (!fifo_empty),
      .data    (fifo_rdata),
      .ser_bit (ser_bit)
   );

   assign tx_bit         = serial_loop ? rx_bit : ser_bit;
   assign tx_clk_from_rx = serial_loop;

   a_r3_clock_select_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clk_from_rx |-> (!prbs_en && !ctl_n));

   a_r6_fifo_never_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_stb |-> !fifo_full);

endmodule

// File: tb/serdes_loop_ctrl_test.sv
`timescale 1ns/1ps
module serdes_loop_ctrl_test;
   localparam int F = 16;
   localparam int NCYC = F * 31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_bit = 1'b0;
   logic [15:0] tx_word = '0;
   logic        prbs_en = 1'b0;
   logic        ctl_n = 1'b1;
   logic        ploop_en = 1'b0;
   logic        tx_bit, tx_clk_from_rx, rx_word_stb, fifo_rst, prbs_clr;
   logic [15:0] rx_word;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   serdes_loop_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .tx_word(tx_word),
      .prbs_en(prbs_en), .ctl_n(ctl_n), .ploop_en(ploop_en),
      .tx_bit(tx_bit), .tx_clk_from_rx(tx_clk_from_rx), .rx_word(rx_word),
      .rx_word_stb(rx_word_stb), .fifo_rst(fifo_rst), .prbs_clr(prbs_clr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input int cyc);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic sch_rx(input int k);
      int v = (k * 37) ^ (k >> 2) ^ (k >> 5);
      return v[0];
   endfunction
   function automatic logic sch_ploop(input int k);
      return (k >= F*8+3) && (k < F*25+5);
   endfunction
   function automatic logic sch_prbs(input int k);
      return (k >= F*20) && (k < F*24);
   endfunction
   function automatic logic sch_ctl(input int k);
      if (k >= F*16+7 && k < F*20) return 1'b0;
      if (k >= F*21+2 && k < F*21+6) return 1'b0;
      if (k == F*22+9) return 1'b0;
      if (k >= F*23+4 && k < F*23+12) return 1'b0;
      if (k >= F*27 && k < F*28+3) return 1'b0;
      return 1'b1;
   endfunction
   function automatic logic [15:0] sch_host(input int k);
      int v = (k / F) * 32'h1357 ^ 32'hA5C3;
      return v[15:0];
   endfunction

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] rxsh, exp_word, cur_tx, pend;
      logic        pend_valid, prev_ploop, prev_ctl, rst_pend, clr_pend;
      rxsh = '0; exp_word = '0; cur_tx = '0; pend = '0;
      pend_valid = 1'b0; prev_ploop = 1'b0; prev_ctl = 1'b1;
      rst_pend = 1'b0; clr_pend = 1'b0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R10: reset state
      check("R10 rx_word", 32'(rx_word), 32'h0, -1);
      check("R10 rx_word_stb", 32'(rx_word_stb), 32'h0, -1);
      check("R10 tx_bit", 32'(tx_bit), 32'h0, -1);
      check("R10 fifo_rst", 32'(fifo_rst), 32'h0, -1);
      check("R10 prbs_clr", 32'(prbs_clr), 32'h0, -1);

      for (int k = 0; k < NCYC; k++) begin
         int j;
         logic sloop, stb, rb, pl, ct, pe;
         if (k > 0) @(negedge clk);
         else rst_n = 1'b1;
         j  = k % F;
         rb = sch_rx(k); pl = sch_ploop(k); ct = sch_ctl(k); pe = sch_prbs(k);
         rx_bit = rb; ploop_en = pl; ctl_n = ct; prbs_en = pe;
         tx_word = sch_host(k);
         #1;
         stb   = (k >= F) && (j == 0);
         sloop = !ct && !pe;
         // R2: strobe timing; R4: unchanged during serial loopback
         check(sloop ? "R4 rx_word_stb" : "R2 rx_word_stb", 32'(rx_word_stb), 32'(stb), k);
         if (stb) begin
            // R1: word content and boundary
            check(sloop ? "R4 rx_word" : "R1 rx_word", 32'(rx_word), 32'(exp_word), k);
         end
         // R3 / R5: clock selection follows the dual-function input only outside PRBS
         check(pe ? "R5 tx_clk_from_rx" : "R3 tx_clk_from_rx", 32'(tx_clk_from_rx), 32'(sloop), k);
         if (sloop) begin
            // R3, R9: straight serial loopback, priority over parallel
            check(pl ? "R9 tx_bit" : "R3 tx_bit", 32'(tx_bit), 32'(rb), k);
         end else begin
            // R7 (R6 picks the word): serializer output
            check(pl ? "R6 tx_bit" : "R7 tx_bit", 32'(tx_bit), 32'(cur_tx[15-j]), k);
         end
         // R8: FIFO reset request
         check("R8 fifo_rst", 32'(fifo_rst), 32'(rst_pend), k);
         // R5: PRBS clear pulse
         check("R5 prbs_clr", 32'(prbs_clr), 32'(clr_pend), k);

         // model state for the end of this cycle
         if (j == F-1) begin
            cur_tx = pend_valid ? pend : 16'h0;
            pend_valid = 1'b0;
         end
         if (rst_pend) begin
            pend_valid = 1'b0;
         end else if (stb) begin
            pend = pl ? exp_word : sch_host(k);
            pend_valid = 1'b1;
         end
         rxsh = {rxsh[14:0], rb};
         if (j == F-1) exp_word = rxsh;
         rst_pend = (pl != prev_ploop);
         prev_ploop = pl;
         clr_pend = pe && prev_ctl && !ct;
         prev_ctl = ct;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule